// File: doc/BRIEF.md
# AC97 Codec Link Controller

This block runs the serial link between a chip and an AC97 audio codec. It sits entirely in the codec's 12.288 MHz bit-clock domain. It produces the frame marker, sends a short fixed series of register-write commands to set up the codec, and then captures the stereo input stream. Each frame lasts 256 bit periods: a 16-bit tag slot and then twelve 20-bit data slots.

Software turns the link on through a START bit that lives in the 50 MHz bus clock domain. The block brings that bit in through a flop synchronizer. While START is low the link stays silent. Once START is high, the block sends one configuration write per frame, in a fixed order. After the last write it streams.

While streaming, the block sends all-zero frames. From the incoming data it takes the left and right capture slots, cuts each one down to its upper 16 bits, and writes the two words into the write port of a clock-crossing FIFO. A write that finds the FIFO full is dropped, and a sticky overflow flag is set. The incoming tag, the status slots and every other slot are ignored.

Top module: `aclink_top`

## Requirements
- R1: After reset with START low, syncOut, sdataOut and wrEn stay low and no frame begins.
- R2: START passes through a two-flop synchronizer. When START rises between two clock edges, syncOut is still low after the first and second following rising edges and is high after the third.
- R3: Once running, syncOut is high for exactly the first 16 bit periods of each frame, and consecutive frames begin 256 bit periods apart. Bit period i of a frame (i = 0..255) is the i-th period counted from the rise of syncOut.
- R4: The first four frames after start are command frames, sent in this order: (address 0x02, data 0x0404), (0x0E, 0x0008), (0x1A, 0x0404), (0x1C, 0x0A0A). In a command frame sdataOut is 1 in periods 0, 1 and 2. Period 16 is 0, meaning write. Periods 17..23 carry the 7-bit address, MSB first. Periods 36..51 carry the 16-bit data, MSB first. Every other period is 0.
- R5: After the configuration frames, sdataOut is 0 in every bit period.
- R6: sdataIn is sampled on the falling clock edge. In a streaming frame whose incoming periods 3 and 4 are both 1, the block makes two writes. The first carries incoming periods 56..71 (left sample, MSB first) and pulses wrEn for one cycle during period 76. The second carries incoming periods 76..91 (right sample) and pulses wrEn during period 96.
- R7: If incoming period 3 or period 4 is 0, the frame makes no write. The values received in periods 0..2, 5..55, 72..75 and 92..255 never change the written data.
- R8: A write that falls due while full is high is not issued, and it sets overflow. Overflow then stays high until reset, and later writes proceed normally.
- R9: Incoming audio received during the command frames is never written.
- R10: If START is low when a frame ends, the link goes idle with syncOut low. When START rises again, the command sequence restarts from its first entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Codec bit clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | START bit from the bus clock domain |
| sdataIn | input | 1 | Serial data from codec |
| full | input | 1 | Downstream FIFO full |
| syncOut | output | 1 | Frame marker to codec |
| sdataOut | output | 1 | Serial data to codec |
| wrEn | output | 1 | FIFO write strobe |
| wrData | output | 16 | Captured sample |
| overflow | output | 1 | Sticky dropped-sample flag |

## Verification
If the bit counter is wrong, the fault shows within one frame: the marker has the wrong length or spacing, or a captured word is taken from the wrong bits and appears in the wrong period. A fault in the sequencer state shows at the next frame boundary: a command frame comes out of order, a command repeats, or a write happens during configuration. A lost tag-valid latch or a broken full test shows on the very next captured pair, either as a missing or extra wrEn pulse or as an overflow flag that does not match the stimulus.

// File: rtl/aclink_pkg.sv
package aclink_pkg;
  localparam int TAG_BITS   = 16;
  localparam int SLOT_BITS  = 20;
  localparam int DATA_SLOTS = 12;
  localparam int SAMPLE_W   = 16;
  localparam int REG_ADDR_W = 7;
  localparam int REG_DATA_W = 16;
  localparam int CFG_COUNT  = 4;
  localparam int CFG_IDX_W  = (CFG_COUNT > 1) ? $clog2(CFG_COUNT) : 1;

  typedef struct packed {
    logic [REG_ADDR_W-1:0] addr;
    logic [REG_DATA_W-1:0] value;
  } cfgWrite_t;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic                 live;
    logic                 cmdFrame;
    logic                 capture;
    logic [CFG_IDX_W-1:0] cfgIdx;
  } linkCtl_t;

  typedef enum logic [1:0] {
    LINK_IDLE   = 2'd0,
    LINK_CONFIG = 2'd1,
    LINK_STREAM = 2'd2
  } linkState_t;

  // fixed codec set-up sequence, applied in index order
  function automatic cfgWrite_t cfgEntry(input logic [CFG_IDX_W-1:0] idx);
    cfgWrite_t w;
    case (idx)
      CFG_IDX_W'(0): w = '{addr: 7'h02, value: 16'h0404};
      CFG_IDX_W'(1): w = '{addr: 7'h0E, value: 16'h0008};
      CFG_IDX_W'(2): w = '{addr: 7'h1A, value: 16'h0404};
      default:       w = '{addr: 7'h1C, value: 16'h0A0A};
    endcase
    return w;
  endfunction
endpackage

// File: rtl/aclink_sync.sv
module aclink_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic dIn,
  output logic dOut
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= dIn;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[STAGES-2:0], dIn};
      end
    end
  endgenerate

  assign dOut = chain[STAGES-1];
endmodule

// File: rtl/aclink_ctrl.sv
module aclink_ctrl
  import aclink_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     startSync,
  input  logic     frameEnd,
  output linkCtl_t ctl
);
  localparam logic [CFG_IDX_W-1:0] LAST_CFG = CFG_IDX_W'(CFG_COUNT - 1);

  linkState_t           state;
  logic [CFG_IDX_W-1:0] cfgIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= LINK_IDLE;
      cfgIdx <= '0;
    end else begin
      case (state)
        LINK_IDLE: begin
          if (startSync) begin
            state  <= LINK_CONFIG;
            cfgIdx <= '0;
          end
        end
        LINK_CONFIG: begin
          if (frameEnd) begin
            if (!startSync)               state  <= LINK_IDLE;
            else if (cfgIdx == LAST_CFG)  state  <= LINK_STREAM;
            else                          cfgIdx <= cfgIdx + 1'b1;
          end
        end
        LINK_STREAM: begin
          if (frameEnd && !startSync) state <= LINK_IDLE;
        end
        default: state <= LINK_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.live     = (state != LINK_IDLE);
    ctl.cmdFrame = (state == LINK_CONFIG);
    ctl.capture  = (state == LINK_STREAM);
    ctl.cfgIdx   = cfgIdx;
  end
endmodule

// File: rtl/aclink_datapath.sv
module aclink_datapath
  import aclink_pkg::*;
#(
  parameter int TAG_W      = TAG_BITS,
  parameter int SLOT_W     = SLOT_BITS,
  parameter int NUM_SLOTS  = DATA_SLOTS,
  parameter int SMP_W      = SAMPLE_W,
  parameter int LEFT_SLOT  = 3,
  parameter int RIGHT_SLOT = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  linkCtl_t         ctl,
  input  logic             sdataIn,
  input  logic             full,
  output logic             frameEnd,
  output logic             syncOut,
  output logic             sdataOut,
  output logic             wrEn,
  output logic [SMP_W-1:0] wrData,
  output logic             overflow
);
  localparam int FRAME_W    = TAG_W + SLOT_W * NUM_SLOTS;
  localparam int CNT_W      = $clog2(FRAME_W);
  localparam int HDR_W      = TAG_W + 2 * SLOT_W;
  localparam int LEFT_LAST  = TAG_W + (LEFT_SLOT - 1) * SLOT_W + SLOT_W - 1;
  localparam int RIGHT_LAST = TAG_W + (RIGHT_SLOT - 1) * SLOT_W + SLOT_W - 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

  // bit position inside the frame
  logic [CNT_W-1:0] bitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  bitCnt <= '0;
    else if (!ctl.live)         bitCnt <= '0;
    else if (bitCnt == LAST_BIT) bitCnt <= '0;
    else                        bitCnt <= bitCnt + 1'b1;
  end

  assign frameEnd = ctl.live && (bitCnt == LAST_BIT);
  assign syncOut  = ctl.live && (bitCnt < CNT_W'(TAG_W));

  // outgoing command header: tag, address slot, data slot
  cfgWrite_t        curCfg;
  logic [HDR_W-1:0] cmdHdr;
  logic [HDR_W-1:0] hdrShifted;

  always_comb begin
    curCfg     = cfgEntry(ctl.cfgIdx);
    cmdHdr     = {3'b111, {(TAG_W-3){1'b0}},
                  1'b0, curCfg.addr, {(SLOT_W-1-REG_ADDR_W){1'b0}},
                  curCfg.value, {(SLOT_W-REG_DATA_W){1'b0}}};
    hdrShifted = cmdHdr << bitCnt;
  end

  assign sdataOut = ctl.live && ctl.cmdFrame && hdrShifted[HDR_W-1];

  // receive: falling-edge sample, rising-edge shift
  logic              sdiNeg;
  logic [SLOT_W-2:0] rxShift;
  logic              leftOk;
  logic              rightOk;

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) sdiNeg <= 1'b0;
    else       sdiNeg <= sdataIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      leftOk  <= 1'b0;
      rightOk <= 1'b0;
    end else if (ctl.live) begin
      rxShift <= {rxShift[SLOT_W-3:0], sdiNeg};
      if (bitCnt == CNT_W'(LEFT_SLOT))  leftOk  <= sdiNeg;
      if (bitCnt == CNT_W'(RIGHT_SLOT)) rightOk <= sdiNeg;
    end
  end

  logic pairOk;
  logic pushDue;

  always_comb begin
    pairOk  = leftOk && rightOk && ctl.live && ctl.capture;
    pushDue = pairOk && ((bitCnt == CNT_W'(LEFT_LAST)) || (bitCnt == CNT_W'(RIGHT_LAST)));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrEn     <= 1'b0;
      wrData   <= '0;
      overflow <= 1'b0;
    end else begin
      wrEn <= pushDue && !full;
      if (pushDue && !full) wrData   <= rxShift[SLOT_W-2 -: SMP_W];
      if (pushDue && full)  overflow <= 1'b1;
    end
  end
endmodule

// File: rtl/aclink_top.sv
module aclink_top
  import aclink_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int LEFT_SLOT   = 3,
  parameter int RIGHT_SLOT  = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startReq,
  input  logic                sdataIn,
  input  logic                full,
  output logic                syncOut,
  output logic                sdataOut,
  output logic                wrEn,
  output logic [SAMPLE_W-1:0] wrData,
  output logic                overflow
);
  logic     startSync;
  logic     frameEnd;
  linkCtl_t ctl;

  aclink_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .dIn  (startReq),
    .dOut (startSync)
  );

  aclink_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startSync (startSync),
    .frameEnd  (frameEnd),
    .ctl       (ctl)
  );

  aclink_datapath #(
    .TAG_W      (TAG_BITS),
    .SLOT_W     (SLOT_BITS),
    .NUM_SLOTS  (DATA_SLOTS),
    .SMP_W      (SAMPLE_W),
    .LEFT_SLOT  (LEFT_SLOT),
    .RIGHT_SLOT (RIGHT_SLOT)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .sdataIn  (sdataIn),
    .full     (full),
    .frameEnd (frameEnd),
    .syncOut  (syncOut),
    .sdataOut (sdataOut),
    .wrEn     (wrEn),
    .wrData   (wrData),
    .overflow (overflow)
  );
endmodule

// File: rtl/aclink_checker.sv
module aclink_checker
  import aclink_pkg::*;
(
  input logic clk,
  input logic rstN,
  input logic syncOut,
  input logic wrEn,
  input logic full,
  input logic overflow
);
  localparam int FRAME_W = TAG_BITS + SLOT_BITS * DATA_SLOTS;
  localparam int GAP_W   = $clog2(FRAME_W) + 2;

  logic             syncPrev;
  logic [GAP_W-1:0] syncRun;
  logic [GAP_W-1:0] gapCnt;
  logic             seenRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncPrev <= 1'b0;
      syncRun  <= '0;
      gapCnt   <= '0;
      seenRise <= 1'b0;
    end else begin
      syncPrev <= syncOut;
      syncRun  <= syncOut ? syncRun + 1'b1 : '0;
      if (syncOut && !syncPrev) begin
        gapCnt   <= GAP_W'(1);
        seenRise <= 1'b1;
      end else if (gapCnt != '1) begin
        gapCnt <= gapCnt + 1'b1;
      end
    end
  end

  // R3: marker lasts exactly the tag slot
  a_r3_sync_width: assert property (@(posedge clk) disable iff (!rstN)
    (!syncOut && syncPrev) |-> (syncRun == GAP_W'(TAG_BITS)));

  // R3: frames never start closer than one frame length apart
  a_r3_frame_gap: assert property (@(posedge clk) disable iff (!rstN)
    (syncOut && !syncPrev) |-> (!seenRise || gapCnt >= GAP_W'(FRAME_W)));

  // R8: no write is issued against a full FIFO
  a_r8_write_needs_room: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> !$past(full));

  // R8: overflow is sticky
  a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);

  // R6: each write is a single-cycle pulse
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> !wrEn);

  // R6: writes never fall inside the tag slot
  a_r6_not_in_tag: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> !syncOut);
endmodule

bind aclink_top aclink_checker u_aclink_checker (
  .clk      (clk),
  .rstN     (rstN),
  .syncOut  (syncOut),
  .wrEn     (wrEn),
  .full     (full),
  .overflow (overflow)
);

// File: tb/tb_aclink_top.sv
`timescale 1ns/1ps
module tb_aclink_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic        sdataIn = 1'b0;
  logic        full = 1'b0;
  logic        syncOut, sdataOut, wrEn, overflow;
  logic [15:0] wrData;

  always #2.5 clk = ~clk;

  aclink_top dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .sdataIn(sdataIn), .full(full),
    .syncOut(syncOut), .sdataOut(sdataOut), .wrEn(wrEn), .wrData(wrData), .overflow(overflow)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // codec model: tracks frame position, feeds sdataIn, records sdataOut
  int           idx = 0;
  bit           inFrame = 0;
  bit           prevSync = 0;
  int           highLen = 0;
  int           lastHigh = 0;
  int           frameCount = 0;
  int           latchCount = 0;
  int           syncRises = 0;
  int           lenErr = 0;
  logic [255:0] nextRx = '0;
  logic [255:0] curRx = '0;
  logic [255:0] txBits = '0;
  logic [255:0] lastTx = '0;

  always begin
    @(posedge clk);
    #1;
    if (syncOut && !prevSync) begin
      if (inFrame && idx != 255) lenErr++;
      idx = 0; inFrame = 1; highLen = 0;
      curRx = nextRx; nextRx = '0; latchCount++; syncRises++;
    end else if (inFrame) begin
      if (idx == 255) inFrame = 0;
      else idx++;
    end
    prevSync = syncOut;
    if (inFrame) begin
      if (syncOut) highLen++;
      if (syncOut && idx >= 16) lenErr++;
      sdataIn = curRx[255-idx];
      txBits[255-idx] = sdataOut;
      if (idx == 255) begin
        lastTx = txBits; lastHigh = highLen; frameCount++;
      end
    end else begin
      sdataIn = 1'b0;
    end
  end

  // scoreboard
  typedef struct { logic [15:0] d; int pos; } exp_t;
  exp_t expQ[$];
  int   writeCount = 0;

  always @(negedge clk) begin
    if (rstN && wrEn === 1'b1) begin
      writeCount++;
      if (expQ.size() == 0) begin
        chk(0, "R7/R9 unexpected write", {240'd0, wrData}, '0);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        chk(wrData == e.d, "R6 sample value", {240'd0, wrData}, {240'd0, e.d});
        chk(idx == e.pos, "R6 write period", idx, e.pos);
      end
    end
  end

  function automatic logic [255:0] cmdVec(input logic [6:0] a, input logic [15:0] d);
    logic [255:0] v;
    v = '0;
    v[255] = 1'b1; v[254] = 1'b1; v[253] = 1'b1;
    for (int i = 0; i < 7; i++)  v[255-(17+i)] = a[6-i];
    for (int i = 0; i < 16; i++) v[255-(36+i)] = d[15-i];
    return v;
  endfunction

  function automatic logic [255:0] rxVec(input bit lv, input bit rv,
                                         input logic [15:0] l, input logic [15:0] r, input bit noise);
    logic [255:0] v;
    logic [19:0]  lw, rw;
    v  = noise ? {64{4'b1011}} : '0;
    lw = {l, noise ? 4'hD : 4'h0};
    rw = {r, noise ? 4'h7 : 4'h0};
    v[255-3] = lv;
    v[255-4] = rv;
    for (int i = 0; i < 20; i++) begin
      v[255-(56+i)] = lw[19-i];
      v[255-(76+i)] = rw[19-i];
    end
    return v;
  endfunction

  task automatic runFrame(input logic [255:0] v, input bit expWr, input logic [15:0] l, input logic [15:0] r);
    int c, f;
    if (expWr) begin
      expQ.push_back('{l, 76});
      expQ.push_back('{r, 96});
    end
    c = latchCount;
    nextRx = v;
    wait (latchCount > c);
    f = frameCount;
    wait (frameCount > f);
  endtask

  logic [6:0]  cfgA [4];
  logic [15:0] cfgD [4];

  initial begin
    cfgA[0] = 7'h02; cfgD[0] = 16'h0404;
    cfgA[1] = 7'h0E; cfgD[1] = 16'h0008;
    cfgA[2] = 7'h1A; cfgD[2] = 16'h0404;
    cfgA[3] = 7'h1C; cfgD[3] = 16'h0A0A;

    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(syncOut == 0 && sdataOut == 0 && wrEn == 0 && overflow == 0, "R1 reset state",
        {syncOut, sdataOut, wrEn, overflow}, '0);
    repeat (50) @(negedge clk);
    chk(syncRises == 0 && syncOut == 0 && sdataOut == 0, "R1 idle without START", syncRises, 0);

    // R9: valid audio offered during the first command frame
    nextRx = rxVec(1, 1, 16'hDEAD, 16'hBEEF, 0);
    @(negedge clk);
    startReq = 1'b1;
    @(posedge clk); #1;
    chk(syncOut == 0, "R2 first edge", syncOut, 0);
    @(posedge clk); #1;
    chk(syncOut == 0, "R2 second edge", syncOut, 0);
    @(posedge clk); #1;
    chk(syncOut == 1, "R2 third edge", syncOut, 1);

    for (int k = 0; k < 4; k++) begin
      int f;
      f = frameCount;
      wait (frameCount > f);
      chk(lastTx == cmdVec(cfgA[k], cfgD[k]), "R4 command frame", lastTx, cmdVec(cfgA[k], cfgD[k]));
      chk(lastHigh == 16, "R3 sync width", lastHigh, 16);
    end
    chk(writeCount == 0, "R9 no capture while configuring", writeCount, 0);

    // streaming
    runFrame(rxVec(1, 1, 16'h1234, 16'hABCD, 0), 1, 16'h1234, 16'hABCD);
    chk(writeCount == 2, "R6 pair written", writeCount, 2);
    chk(lastTx == '0, "R5 stream frame silent", lastTx, '0);
    runFrame(rxVec(1, 1, 16'h8001, 16'h7FFE, 0), 1, 16'h8001, 16'h7FFE);
    chk(writeCount == 4, "R6 second pair", writeCount, 4);
    runFrame(rxVec(1, 0, 16'h5555, 16'h6666, 0), 0, 16'h0, 16'h0);
    chk(writeCount == 4, "R7 right invalid", writeCount, 4);
    runFrame(rxVec(0, 1, 16'h7777, 16'h8888, 0), 0, 16'h0, 16'h0);
    chk(writeCount == 4, "R7 left invalid", writeCount, 4);
    runFrame(rxVec(1, 1, 16'hC3A5, 16'h0F0F, 1), 1, 16'hC3A5, 16'h0F0F);
    chk(writeCount == 6, "R7 noise ignored", writeCount, 6);
    chk(lastTx == '0, "R5 stream frame silent again", lastTx, '0);

    full = 1'b1;
    runFrame(rxVec(1, 1, 16'h1111, 16'h2222, 0), 0, 16'h0, 16'h0);
    chk(writeCount == 6, "R8 dropped when full", writeCount, 6);
    chk(overflow == 1, "R8 overflow set", overflow, 1);
    full = 1'b0;
    runFrame(rxVec(1, 1, 16'h3333, 16'h4444, 0), 1, 16'h3333, 16'h4444);
    chk(writeCount == 8, "R8 writes resume", writeCount, 8);
    chk(overflow == 1, "R8 overflow sticky", overflow, 1);

    // R10: stop and restart
    begin
      int f, r;
      wait (idx == 255);
      startReq = 1'b0;
      f = frameCount;
      wait (frameCount > f);
      r = syncRises;
      repeat (300) @(negedge clk);
      chk(syncRises == r && syncOut == 0, "R10 idle after stop", syncRises, r);
      startReq = 1'b1;
      f = frameCount;
      wait (frameCount > f);
      chk(lastTx == cmdVec(cfgA[0], cfgD[0]), "R10 sequence restarts", lastTx, cmdVec(cfgA[0], cfgD[0]));
    end

    chk(lenErr == 0, "R3 frame length", lenErr, 0);
    chk(expQ.size() == 0, "R6 all expected writes seen", expQ.size(), 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule